// File: doc/BRIEF.md
# Heterogeneous One-Dimensional Cellular Automaton

This block is a line of binary cells that advance together, one generation per enabled clock step. Each cell computes its next value from three bits: its left neighbour, its own value and its right neighbour. A global rule is not used. Every cell owns a private 8-bit lookup table, so any Boolean function of those three bits can be placed at any position and neighbouring cells may run different rules.

Rule tables are written through a single serial shift chain that threads every cell. A parallel load seeds the generation, and the full state is visible on a parallel output. A parameter selects whether the two end cells see a constant zero beyond the edge or close the line into a ring.

A typical sequence is reset, shift in all rule bits, load a starting pattern, then pulse the step enable and read the resulting generations.

Top module: `ca1d_array`

## Requirements
- R1: A synchronous active-low reset sets every state bit to 0 and every rule bit to 0, so a step taken right after reset gives all zeros whatever state was loaded.
- R2: On an enabled step, cell i takes the value rule_i[idx], where idx = {left, own, right} with left as bit 2. The left neighbour of cell i is cell i+1 and the right neighbour is cell i-1, where cell i is bit i of the state.
- R3: All cells update together from the state of the previous generation. No cell sees a value that another cell produced in the same step.
- R4: With WRAP = 0, the left input of the highest cell and the right input of cell 0 are a constant 0.
- R5: With WRAP = 1, the left input of the highest cell is cell 0 and the right input of cell 0 is the highest cell.
- R6: Each shift pulse moves the whole rule chain down by one bit and places cfg_din at the top bit. Cell i's rule occupies chain bits i*8 to i*8+7, with rule bit k at i*8+k. After N_CELLS*8 pulses, the first bit sent lands in rule bit 0 of cell 0.
- R7: While cfg_shift_en is 1, no step takes effect, even if step_en is 1.
- R8: When load_en is 1, state_q becomes load_state on the next edge. This takes priority over a step and also applies while shifting.
- R9: When neither load_en nor step_en is 1, the state holds.
- R10: Rule bits change only on shift pulses and on reset. They stay the same across any number of steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Advance one generation |
| cfg_shift_en | input | 1 | Shift one bit into the rule chain |
| cfg_din | input | 1 | Serial rule data |
| load_en | input | 1 | Write load_state into the cells |
| load_state | input | N_CELLS | Starting generation |
| state_q | output | N_CELLS | Current generation |

## Verification
A corrupt rule bit does not show at the ports until a step applies that cell's table to the neighbourhood that indexes the bad bit. For that reason the patterns cover many neighbourhood values over several generations. A wrong cell state shows on state_q in the very next cycle, and through the neighbour links it reaches one further cell in each later step. A fault in the edge links only appears when an end cell's missing neighbour would matter, so both edge settings are run side by side on the same inputs.

// File: rtl/ca1d_pkg.sv
// Shared constants and types for the cellular automaton array.
package ca1d_pkg;
    localparam int RULE_W = 8;
    localparam int NBHD_W = 3;

    typedef logic [RULE_W-1:0] rule_t;

    // Neighbourhood as seen by one cell; left is the index MSB.
    typedef struct packed {
        logic left;
        logic mid;
        logic right;
    } nbhd_t;
endpackage

// File: rtl/ca1d_rule_chain.sv
// Serial rule store: one shift register holding every cell's table.
// Assumes cfg data enters at the top bit and moves toward bit 0, so
// the first bit sent ends up in cell 0, rule bit 0.
module ca1d_rule_chain
    import ca1d_pkg::*;
#(
    parameter int N_CELLS = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         shift_en,
    input  logic                         din,
    output logic [N_CELLS*RULE_W-1:0]    chain_q
);
    localparam int CHAIN_W = N_CELLS * RULE_W;

    // Shift the chain by one bit per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q <= '0;
        else if (shift_en)
            chain_q <= {din, chain_q[CHAIN_W-1:1]};
    end
endmodule

// File: rtl/ca1d_neighbour.sv
// Neighbour routing: gives each cell its left (i+1) and right (i-1)
// inputs. WRAP selects a ring, otherwise the edges read constant 0.
// Assumes N_CELLS >= 2.
module ca1d_neighbour #(
    parameter int N_CELLS = 16,
    parameter bit WRAP    = 1'b0
) (
    input  logic [N_CELLS-1:0] state_i,
    output logic [N_CELLS-1:0] left_o,
    output logic [N_CELLS-1:0] right_o
);
    localparam int TOP = N_CELLS - 1;

    for (genvar i = 0; i < N_CELLS; i++) begin : g_link
        // Left input of cell i.
        if (i == TOP) begin : g_left_edge
            if (WRAP) begin : g_ring
                assign left_o[i] = state_i[0];
            end else begin : g_zero
                assign left_o[i] = 1'b0;
            end
        end else begin : g_left_inner
            assign left_o[i] = state_i[i+1];
        end

        // Right input of cell i.
        if (i == 0) begin : g_right_edge
            if (WRAP) begin : g_ring
                assign right_o[i] = state_i[TOP];
            end else begin : g_zero
                assign right_o[i] = 1'b0;
            end
        end else begin : g_right_inner
            assign right_o[i] = state_i[i-1];
        end
    end
endmodule

// File: rtl/ca1d_cell.sv
// One automaton site: a state flop updated from its own lookup table.
// Priority is load, then step, then hold. Assumes step_ok is already
// gated off while the rule chain is shifting.
module ca1d_cell
    import ca1d_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_en,
    input  logic  load_val,
    input  logic  step_ok,
    input  logic  left,
    input  logic  right,
    input  rule_t rule,
    output logic  state_o
);
    nbhd_t nb;
    logic  next_val;

    // Form the table index and look up the next value.
    always_comb begin
        nb       = '{left: left, mid: state_o, right: right};
        next_val = rule[nb];
    end

    // State register with load priority over a step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_o <= 1'b0;
        else if (load_en)
            state_o <= load_val;
        else if (step_ok)
            state_o <= next_val;
    end
endmodule

// File: rtl/ca1d_array.sv
// Top level: a line of cells, each with a private 3-input lookup table,
// fed from a serial rule chain. Steps are held off while shifting.
module ca1d_array
    import ca1d_pkg::*;
#(
    parameter int N_CELLS = 16,
    parameter bit WRAP    = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_en,
    input  logic               cfg_shift_en,
    input  logic               cfg_din,
    input  logic               load_en,
    input  logic [N_CELLS-1:0] load_state,
    output logic [N_CELLS-1:0] state_q
);
    localparam int CHAIN_W = N_CELLS * RULE_W;

    logic [CHAIN_W-1:0] rule_chain;
    logic [N_CELLS-1:0] left_in;
    logic [N_CELLS-1:0] right_in;
    logic               step_ok;

    // A step is allowed only when the chain is not moving.
    assign step_ok = step_en & ~cfg_shift_en;

    ca1d_rule_chain #(.N_CELLS(N_CELLS)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_shift_en),
        .din      (cfg_din),
        .chain_q  (rule_chain)
    );

    ca1d_neighbour #(.N_CELLS(N_CELLS), .WRAP(WRAP)) u_nbr (
        .state_i (state_q),
        .left_o  (left_in),
        .right_o (right_in)
    );

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        ca1d_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_en  (load_en),
            .load_val (load_state[i]),
            .step_ok  (step_ok),
            .left     (left_in[i]),
            .right    (right_in[i]),
            .rule     (rule_chain[i*RULE_W +: RULE_W]),
            .state_o  (state_q[i])
        );
    end
endmodule

// File: rtl/ca1d_array_chk.sv
// Property checker for ca1d_array, attached by bind below.
module ca1d_array_chk #(
    parameter int N_CELLS = 16,
    parameter int CHAIN_W = 128
) (
    input logic               clk,
    input logic               rst_n,
    input logic               step_en,
    input logic               cfg_shift_en,
    input logic               cfg_din,
    input logic               load_en,
    input logic [N_CELLS-1:0] load_state,
    input logic [N_CELLS-1:0] state_q,
    input logic [CHAIN_W-1:0] rule_chain
);
    // R1: leaving reset, the state is all zero.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state_q == '0));

    // R6: a shift pulse places cfg_din at the chain top.
    p_shift_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift_en |=> (rule_chain[CHAIN_W-1] == $past(cfg_din)));

    // R7: shifting without a load freezes the state.
    p_shift_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_shift_en && !load_en) |=> $stable(state_q));

    // R8: a load wins over any step.
    p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (state_q == $past(load_state)));

    // R9: idle cycles hold the state.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !step_en) |=> $stable(state_q));

    // R10: rules move only on shift pulses.
    p_rules_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_shift_en |=> $stable(rule_chain));
endmodule

bind ca1d_array ca1d_array_chk #(
    .N_CELLS (N_CELLS),
    .CHAIN_W (N_CELLS * ca1d_pkg::RULE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_en      (step_en),
    .cfg_shift_en (cfg_shift_en),
    .cfg_din      (cfg_din),
    .load_en      (load_en),
    .load_state   (load_state),
    .state_q      (state_q),
    .rule_chain   (rule_chain)
);

// File: tb/ca1d_array_tb.sv
module ca1d_array_tb;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         step_en = 1'b0;
    logic         cfg_shift_en = 1'b0;
    logic         cfg_din = 1'b0;
    logic         load_en = 1'b0;
    logic [N-1:0] load_state = '0;
    logic [N-1:0] state_line;
    logic [N-1:0] state_ring;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [63:0]  m_rules;
    logic [N-1:0] m_line;
    logic [N-1:0] m_ring;

    always #5 clk = ~clk;

    ca1d_array #(.N_CELLS(N), .WRAP(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .cfg_shift_en(cfg_shift_en),
        .cfg_din(cfg_din), .load_en(load_en), .load_state(load_state),
        .state_q(state_line)
    );

    ca1d_array #(.N_CELLS(N), .WRAP(1'b1)) u_dut_ring (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .cfg_shift_en(cfg_shift_en),
        .cfg_din(cfg_din), .load_en(load_en), .load_state(load_state),
        .state_q(state_ring)
    );

    // Stimulus table: {rules for cells 7..0, starting state}.
    localparam logic [71:0] VEC [6] = '{
        {64'h5A5A_5A5A_5A5A_5A5A, 8'h10},
        {64'h1E1E_1E1E_1E1E_1E1E, 8'h08},
        {64'h6E6E_6E6E_6E6E_6E6E, 8'h01},
        {64'hCCCC_CCCC_CCCC_CCCC, 8'hA5},
        {64'hFF00_CC96_6E1E_5AF0, 8'h3C},
        {64'h0123_4567_89AB_CDEF, 8'hC3}
    };

    function automatic logic [N-1:0] model_step(input logic [N-1:0] s,
                                                 input logic [63:0] r,
                                                 input bit wrap);
        logic [N-1:0] n;
        for (int i = 0; i < N; i++) begin
            logic l, rt;
            logic [2:0] idx;
            l   = (i == N-1) ? (wrap ? s[0] : 1'b0) : s[(i+1) % N];
            rt  = (i == 0) ? (wrap ? s[N-1] : 1'b0) : s[(i+N-1) % N];
            idx = {l, s[i], rt};
            n[i] = r[i*8 + int'(idx)];
        end
        return n;
    endfunction

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic shift_rules(input logic [63:0] r);
        for (int k = 0; k < 64; k++) begin
            cfg_shift_en = 1'b1;
            cfg_din = r[k];
            @(negedge clk);
        end
        cfg_shift_en = 1'b0;
        cfg_din = 1'b0;
        m_rules = r;
    endtask

    task automatic load(input logic [N-1:0] v);
        load_en = 1'b1;
        load_state = v;
        @(negedge clk);
        load_en = 1'b0;
        m_line = v;
        m_ring = v;
    endtask

    task automatic step_once();
        step_en = 1'b1;
        @(negedge clk);
        step_en = 1'b0;
        m_line = model_step(m_line, m_rules, 1'b0);
        m_ring = model_step(m_ring, m_rules, 1'b1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset line", state_line, '0);
        check("R1 reset ring", state_ring, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: rules are zero after reset, so a step clears a full pattern
        m_rules = '0;
        load(8'hFF);
        step_once();
        check("R1 zero rules", state_line, 8'h00);

        // Table walk: R2 R3 R4 R5 R6 R8 R10
        for (int v = 0; v < 6; v++) begin
            shift_rules(VEC[v][71:8]);
            load(VEC[v][7:0]);
            check("R8 load", state_line, VEC[v][7:0]);
            for (int s = 0; s < 3; s++) begin
                step_once();
                check("R2 R3 R4 R6 R10 line", state_line, m_line);
                check("R5 ring", state_ring, m_ring);
            end
        end

        // R4 edge zero: rule 0xF0 copies left; top cell must take 0
        shift_rules({8{8'hF0}});
        load(8'h81);
        step_once();
        check("R4 edge line", state_line, 8'h40);
        check("R5 edge ring", state_ring, 8'hC0);

        // R7: shift pulse with step_en high leaves the state alone
        shift_rules(64'hFF00_CC96_6E1E_5AF0);
        load(8'h96);
        step_en = 1'b1;
        cfg_shift_en = 1'b1;
        cfg_din = 1'b1;
        @(negedge clk);
        step_en = 1'b0;
        cfg_shift_en = 1'b0;
        cfg_din = 1'b0;
        check("R7 shift hold", state_line, 8'h96);
        // R6: single pulse moved the chain down one bit
        m_rules = {1'b1, m_rules[63:1]};
        step_once();
        check("R6 one pulse", state_line, m_line);

        // R8: load and step together, load wins
        load_en = 1'b1;
        step_en = 1'b1;
        load_state = 8'h5A;
        @(negedge clk);
        load_en = 1'b0;
        step_en = 1'b0;
        m_line = 8'h5A;
        m_ring = 8'h5A;
        check("R8 priority", state_line, 8'h5A);

        // R9: idle cycles hold
        repeat (4) @(negedge clk);
        check("R9 idle hold", state_line, 8'h5A);

        // R1: reset mid-run clears rules and state
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset", state_line, 8'h00);
        rst_n = 1'b1;
        m_rules = '0;
        load(8'hE7);
        step_once();
        check("R1 rules cleared", state_line, 8'h00);

        finish_run();
    end
endmodule